// File: doc/BRIEF.md
# Synchronized Multi-Channel PWM Generator

This block produces one pulse-width-modulated output for each of its submodules (four by default), all clocked together. Each submodule has a 16-bit up-counter, a period register and a compare register. The counter runs from zero to the period value and then wraps. The output stays low until the count reaches the compare value and is high from there up to the period value.

Software writes the period and the compare value into shadow copies. The shadow copies have no effect on the output until they are committed. A commit is armed by setting a per-submodule load-enable bit through a shared mask write. It then takes place only at the next wrap of the counter. The load-enable bit clears itself at the commit, so software can poll it to learn that the update has landed.

Submodule 0 acts as the master. Any submodule can restart its counter on the master's wrap pulse instead of on its own terminal count. Any submodule can also take its commit from the master: its shadow values then land only when the master's load-enable bit is set and the master's counter wraps. The submodule's own load-enable bit plays no part in that case.

Top module: `pwm_sync_array`

## Requirements
- R1: After reset every counter is 0, every load-enable bit is 0, and each submodule runs with period 15 and compare value 8, so every output is low at the first cycle after reset.
- R2: A write to the compare buffer (address field 0) or the period buffer (address field 1) does not change the output waveform until a commit takes place.
- R3: With init select code 0 (own restart), the counter counts 0, 1, … up to the active period value P and then returns to 0, so one PWM cycle lasts P+1 clocks.
- R4: The output is low while count < C and high while C ≤ count ≤ P, where C is the active compare value. C = 0 gives an output that is always high. C > P gives an output that is always low.
- R5: A commit happens only at the submodule's counter wrap and never at the moment the load-enable bit is written. The load-enable bit clears in the same clock in which the counter returns to 0 with the new values.
- R6: A write to address field 3 sets the load-enable bit of every submodule whose bit is 1 in wr_data[NUM_SUB-1:0]. Bits written as 0 leave their load-enable bits unchanged.
- R7: The control register is at address field 2. Its bits [1:0] hold the init select. With init select code 2, the counter returns to 0 on the master wrap pulse and ignores its own period.
- R8: With control bit 2 set (master reload), the submodule's shadow values commit only in a cycle where submodule 0's load-enable bit is set and submodule 0's counter wraps. The submodule's own load-enable bit alone commits nothing, and it is cleared by that master commit.
- R9: The master wrap pulse is one clock wide and falls in the cycle in which submodule 0's count equals its period. Submodules that restart on it show a count of 0 together with submodule 0 on the next cycle.
- R10: A period of 1600 counts is supported. P = 1599 with C = 1200 gives 400 high clocks per 1600-clock cycle, which is 25 % duty.

Register address: wr_addr[ADDR_W-1:2] selects the submodule, and wr_addr[1:0] selects the field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all submodules |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Submodule index in the upper bits, field code in the lower two bits |
| wr_data | input | CNT_W (16) | Write data |
| pwm_o | output | NUM_SUB (4) | One PWM output per submodule |
| ldok_o | output | NUM_SUB (4) | Pending load-enable bits, one per submodule |
| cnt_o | output | NUM_SUB*CNT_W (64) | Counter values, submodule s in bits [s*CNT_W +: CNT_W] |

## Verification
The bench builds the block with its default parameters: four submodules, 16-bit counters, and a reset period of 15 with a reset compare value of 8. Because the reset period is short, a wrap arrives every 16 clocks. This makes commit timing, master restart and master-driven reload observable within a few dozen cycles. With 16-bit counters, the bench can also load a 1600-count period and measure its 25 % duty within the run.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  // address field codes (wr_addr[1:0])
  localparam logic [1:0] FLD_CMP = 2'd0;
  localparam logic [1:0] FLD_PER = 2'd1;
  localparam logic [1:0] FLD_CTL = 2'd2;
  localparam logic [1:0] FLD_LDM = 2'd3;

  // init select codes
  localparam logic [1:0] INIT_LOCAL  = 2'd0;
  localparam logic [1:0] INIT_MASTER = 2'd2;

  typedef struct packed {
    logic       reload_master;  // bit 2
    logic [1:0] init_sel;       // bits 1:0
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);

endpackage

// File: rtl/pwm_ldok_ctrl.sv
module pwm_ldok_ctrl #(
  parameter int NUM_SUB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SUB-1:0] set_mask,
  input  logic [NUM_SUB-1:0] xfer,
  output logic [NUM_SUB-1:0] ldok
);

  logic [NUM_SUB-1:0] ldok_q;

  // a new request in the commit cycle wins, so it is not lost
  always_ff @(posedge clk) begin
    if (!rst_n) ldok_q <= '0;
    else        ldok_q <= (ldok_q & ~xfer) | set_mask;
  end

  assign ldok = ldok_q;

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_chk
    // R5: commit retires the request
    assert_ldok_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer[i] && !set_mask[i]) |=> !ldok_q[i]);
    // R6: a request stays pending until a commit consumes it
    assert_ldok_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ldok_q[i] && !xfer[i]) |=> ldok_q[i]);
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_sync_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_PERIOD = 15,
  parameter int RST_DUTY   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmp,
  input  logic             wr_per,
  input  logic             wr_ctl,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             master_sync,
  input  logic             master_reload_ok,
  input  logic             ldok_self,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o,
  output logic             term_o,
  output logic             xfer_o
);

  localparam logic [CNT_W-1:0] PER_RST = CNT_W'(RST_PERIOD);
  localparam logic [CNT_W-1:0] CMP_RST = CNT_W'(RST_DUTY);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_buf, per_buf;
  logic [CNT_W-1:0] cmp_act, per_act;
  chan_ctrl_t       ctl_q;
  logic             init_evt;

  // count has reached (or passed) the period value
  function automatic logic at_terminal(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] p);
    return c >= p;
  endfunction

  // output level for a count, compare value and period
  function automatic logic level_of(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] cmpv,
                                    input logic [CNT_W-1:0] p);
    return (c >= cmpv) && (c <= p);
  endfunction

  assign term_o   = at_terminal(cnt_q, per_act);
  assign init_evt = (ctl_q.init_sel == INIT_MASTER) ? master_sync : term_o;
  assign xfer_o   = ctl_q.reload_master ? master_reload_ok
                                        : (init_evt && ldok_self);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (init_evt) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_buf <= CMP_RST;
      per_buf <= PER_RST;
      ctl_q   <= '0;
    end else begin
      if (wr_cmp) cmp_buf <= wr_data;
      if (wr_per) per_buf <= wr_data;
      if (wr_ctl) ctl_q   <= chan_ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_act <= CMP_RST;
      per_act <= PER_RST;
    end else if (xfer_o) begin
      cmp_act <= cmp_buf;
      per_act <= per_buf;
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = level_of(cnt_q, cmp_act, per_act);

  // R3: a restart event brings the count back to zero
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> cnt_q == '0);
  // R3: otherwise the counter advances by one
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_evt |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R2: active values move only on a commit
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_o |=> ($stable(cmp_act) && $stable(per_act)));
  // R4: compare value zero keeps the output high within the period
  assert_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0 && cnt_q <= per_act) |-> pwm_o);
  // R4: compare value beyond the period keeps the output low
  assert_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act > per_act) |-> !pwm_o);
  // R8: a master-sourced commit only at the master wrap
  assert_slave_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.reload_master && xfer_o) |-> master_sync);

endmodule

// File: rtl/pwm_sync_array.sv
module pwm_sync_array
  import pwm_sync_pkg::*;
#(
  parameter int NUM_SUB    = 4,
  parameter int CNT_W      = 16,
  parameter int RST_PERIOD = 15,
  parameter int RST_DUTY   = 8,
  localparam int SUB_W     = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
  localparam int ADDR_W    = SUB_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CNT_W-1:0]         wr_data,
  output logic [NUM_SUB-1:0]       pwm_o,
  output logic [NUM_SUB-1:0]       ldok_o,
  output logic [NUM_SUB*CNT_W-1:0] cnt_o
);

  logic [SUB_W-1:0]   wr_sub;
  logic [1:0]         wr_fld;
  logic [NUM_SUB-1:0] set_mask;
  logic [NUM_SUB-1:0] xfer;
  logic [NUM_SUB-1:0] term;
  logic [NUM_SUB-1:0] ldok;
  logic               master_sync;
  logic               master_reload_ok;

  assign wr_sub = wr_addr[ADDR_W-1:2];
  assign wr_fld = wr_addr[1:0];

  assign set_mask = (wr_en && wr_fld == FLD_LDM) ? wr_data[NUM_SUB-1:0] : '0;

  // master events come from submodule 0
  assign master_sync      = term[0];
  assign master_reload_ok = master_sync && ldok[0];

  pwm_ldok_ctrl #(.NUM_SUB(NUM_SUB)) u_ldok (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask),
    .xfer     (xfer),
    .ldok     (ldok)
  );

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    logic sel;
    assign sel = wr_en && (wr_sub == SUB_W'(s));

    pwm_chan #(
      .CNT_W      (CNT_W),
      .RST_PERIOD (RST_PERIOD),
      .RST_DUTY   (RST_DUTY)
    ) u_chan (
      .clk              (clk),
      .rst_n            (rst_n),
      .wr_cmp           (sel && wr_fld == FLD_CMP),
      .wr_per           (sel && wr_fld == FLD_PER),
      .wr_ctl           (sel && wr_fld == FLD_CTL),
      .wr_data          (wr_data),
      .master_sync      (master_sync),
      .master_reload_ok (master_reload_ok),
      .ldok_self        (ldok[s]),
      .cnt_o            (cnt_o[s*CNT_W +: CNT_W]),
      .pwm_o            (pwm_o[s]),
      .term_o           (term[s]),
      .xfer_o           (xfer[s])
    );
  end

  assign ldok_o = ldok;

  // R9: the master pulse is a single clock wide
  assert_sync_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    master_sync |=> !master_sync);
  // R9: after the master pulse the master count restarts at zero
  assert_sync_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    master_sync |=> cnt_o[CNT_W-1:0] == '0);

endmodule

// File: tb/pwm_sync_array_test.sv
module pwm_sync_array_test;

  localparam int NS = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NS-1:0] pwm_o, ldok_o;
  logic [NS*CW-1:0] cnt_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwm_sync_array uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o), .ldok_o(ldok_o), .cnt_o(cnt_o)
  );

  // {period, compare} pairs for submodule 1
  localparam logic [31:0] VEC [0:5] = '{
    {16'd15,   16'd8},
    {16'd9,    16'd0},
    {16'd9,    16'd9},
    {16'd9,    16'd12},
    {16'd31,   16'd1},
    {16'd1599, 16'd1200}
  };

  function automatic int cnt_of(int s);
    return int'(cnt_o[s*CW +: CW]);
  endfunction

  function automatic int expect_high(int per, int cmpv);
    if (cmpv > per) return 0;
    return per - cmpv + 1;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int s, int fld, int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 4'((s << 2) | fld);
    wr_data = CW'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_clear(int s, string req);
    for (int i = 0; i < 5000; i++) begin
      if (!ldok_o[s]) return;
      @(negedge clk);
    end
    check(req, 1, 0);
  endtask

  // one PWM cycle starting at count 0: high clocks and length
  task automatic measure(int s, output int hi, output int len);
    hi = 0; len = 0;
    for (int i = 0; i < 70000 && cnt_of(s) != 0; i++) @(negedge clk);
    do begin
      if (pwm_o[s]) hi++;
      len++;
      @(negedge clk);
    end while (cnt_of(s) != 0 && len < 70000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi, len, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 counters", int'(cnt_o == '0), 1);
    check("R1 ldok", int'(ldok_o), 0);
    check("R1 outputs", int'(pwm_o), 0);
    measure(0, hi, len);
    check("R1 reset high time", hi, 8);
    check("R1 R3 reset period", len, 16);

    // table: R3 R4 R5 R10 on submodule 1
    foreach (VEC[k]) begin
      int per, cmpv;
      per  = int'(VEC[k][31:16]);
      cmpv = int'(VEC[k][15:0]);
      wr(1, 0, cmpv);
      wr(1, 1, per);
      wr(0, 3, 2);
      wait_clear(1, "R5 commit");
      measure(1, hi, len);
      check($sformatf("R4 R10 high vec%0d", k), hi, expect_high(per, cmpv));
      check($sformatf("R3 length vec%0d", k), len, per + 1);
    end

    // R2: buffered compare write alone changes nothing
    wr(2, 0, 2);
    repeat (20) @(negedge clk);
    measure(2, hi, len);
    check("R2 no commit", hi, 8);

    // R6: zero mask has no effect
    wr(0, 3, 0);
    check("R6 zero mask", int'(ldok_o), 0);
    // align write away from the wrap
    for (int i = 0; i < 40 && cnt_of(2) != 3; i++) @(negedge clk);
    wr(0, 3, 4);
    check("R6 R5 pending", int'(ldok_o), 4);
    wait_clear(2, "R5 commit sub2");
    check("R5 clear at wrap", cnt_of(2), 0);
    measure(2, hi, len);
    check("R2 after commit", hi, 14);

    // R7 R9: submodule 3 restarts on master wrap
    wr(3, 1, 40);
    wr(0, 3, 8);
    wait_clear(3, "R5 commit sub3");
    wr(3, 2, 2);
    for (int i = 0; i < 40 && cnt_of(0) != 15; i++) @(negedge clk);
    @(negedge clk);
    check("R9 master zero", cnt_of(0), 0);
    check("R7 slave zero", cnt_of(3), 0);
    bad = 0;
    for (int i = 0; i < 48; i++) begin
      if (cnt_of(3) != cnt_of(0)) bad++;
      @(negedge clk);
    end
    check("R7 lockstep", bad, 0);

    // R8: master-sourced reload
    wr(3, 2, 6);
    wr(3, 0, 5);
    wr(0, 3, 8);
    repeat (40) @(negedge clk);
    check("R8 own ldok ignored", int'(ldok_o[3]), 1);
    measure(3, hi, len);
    check("R8 no commit yet", hi, 8);
    wr(0, 3, 1);
    wait_clear(3, "R8 master commit");
    check("R8 master ldok cleared", int'(ldok_o[0]), 0);
    check("R8 commit at master wrap", cnt_of(3), 0);
    measure(3, hi, len);
    check("R8 new compare", hi, 11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule